// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block removes returns from stationary targets in a stream of complex range samples. Each input sample carries a range bin index. For every bin the block keeps the sample seen on the previous chirp. When cancellation is on, it outputs the current sample minus that stored one, which is a first-order difference across chirps. This places a null at zero Doppler. Each input sample is written into the history after it has been used, so the next chirp subtracts it.

A chirp that has no predecessor cannot be cancelled. A status flag marks this priming phase, and the block outputs zeros while it lasts. The phase starts after reset and lasts for as long as cancellation is off. It ends when bin 0 of the following chirp arrives.

Differences are formed one bit wider than the data and clamped to the signed data range. A saturating counter records how many output samples were clamped. With cancellation off, the block acts as a one-cycle register stage that passes the samples through unchanged.

Top module: `clutter_canceller`

## Requirements
- R1: With enable high and the priming phase over, each valid output equals the input sample minus the sample last stored for the same bin, computed separately for I and Q.
- R2: Every output follows its input by exactly one clock. out_valid equals in_valid from the previous cycle, and out_bin equals the bin of that input. A cycle without in_valid gives out_valid low.
- R3: With enable low, a valid input appears one clock later unchanged on out_i and out_q.
- R4: out_first is high after reset and stays high while enable is low. While it is high and enable is high, valid outputs carry zero in both I and Q.
- R5: During priming, a valid input with bin 0 clears out_first, but only if at least one valid sample has already been taken in that priming phase. That bin 0 sample produces a real difference (R1). A priming phase that begins mid-chirp lasts until bin 0 of the next chirp.
- R6: Each difference is clamped to the range -2^(DATA_W-1) to 2^(DATA_W-1)-1.
- R7: sat_count increments by one for each cancelled output where I or Q was clamped, whether one lane or both. It holds at its maximum value, 255 for the default width, and is unchanged by bypassed or primed samples.
- R8: Reset clears out_valid, out_i, out_q, out_bin, sat_count and the stored history to zero, and sets out_first.
- R9: Every valid input is written to the history for its bin, whether the block is bypassing, priming or cancelling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = cancel, 0 = pass through |
| in_valid | input | 1 | Input sample strobe |
| in_bin | input | BIN_W | Range bin of the input sample |
| in_i | input | DATA_W | Input in-phase, signed |
| in_q | input | DATA_W | Input quadrature, signed |
| out_valid | output | 1 | Output sample strobe |
| out_bin | output | BIN_W | Range bin of the output sample |
| out_i | output | DATA_W | Output in-phase, signed |
| out_q | output | DATA_W | Output quadrature, signed |
| out_first | output | 1 | Priming phase, no previous chirp held |
| sat_count | output | CNT_W | Saturating count of clamped outputs |

## Verification
The bench builds the block with BINS = 8, so BIN_W = 3, and keeps DATA_W = 16 and CNT_W = 8. The short chirp lets many chirps run within a brief test. That is enough full-scale sign swings to drive the clamp counter past 255 and check that it holds there. It also reaches enabling mid-chirp, priming that ends on bin 0, and idle gaps between samples. Keeping 16-bit data keeps the clamp boundaries at the real extremes of -32768 and 32767.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

    // How the current input sample is turned into an output sample.
    typedef enum logic [1:0] {
        CCL_BYPASS = 2'd0,
        CCL_PRIME  = 2'd1,
        CCL_CANCEL = 2'd2
    } ccl_mode_e;

endpackage

// File: rtl/ccl_history_mem.sv
module ccl_history_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [DATA_W-1:0] wr_i,
    input  logic signed [DATA_W-1:0] wr_q,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [DATA_W-1:0] rd_i,
    output logic signed [DATA_W-1:0] rd_q
);

    localparam int ENTRY_W = 2 * DATA_W;

    logic [ENTRY_W-1:0] entry_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic [ENTRY_W-1:0] entry_d;
        logic               hit;

        always_comb begin
            hit     = wr_en && (wr_addr == ADDR_W'(e));
            entry_d = hit ? {wr_i, wr_q} : entry_q[e];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[e] <= '0;
            end else begin
                entry_q[e] <= entry_d;
            end
        end
    end

    always_comb begin
        rd_i = entry_q[rd_addr][ENTRY_W-1:DATA_W];
        rd_q = entry_q[rd_addr][DATA_W-1:0];
    end

endmodule

// File: rtl/ccl_sat_lane.sv
module ccl_sat_lane #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] cur,
    input  logic signed [DATA_W-1:0] prev,
    output logic signed [DATA_W-1:0] diff,
    output logic                     clipped
);

    localparam int WIDE_W = DATA_W + 1;
    localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [WIDE_W-1:0] wide;

    always_comb begin
        wide = WIDE_W'(cur) - WIDE_W'(prev);
        // Overflow whenever the two top bits of the wide result disagree.
        clipped = wide[WIDE_W-1] ^ wide[WIDE_W-2];
        if (!clipped) begin
            diff = wide[DATA_W-1:0];
        end else if (wide[WIDE_W-1]) begin
            diff = MIN_V;
        end else begin
            diff = MAX_V;
        end
    end

endmodule

// File: rtl/ccl_sat_counter.sv
module ccl_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_d;
    logic [CNT_W-1:0] count_q;

    always_comb begin
        count_d = count_q;
        if (bump && (count_q != TOP)) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/clutter_canceller.sv
module clutter_canceller #(
    parameter int DATA_W = 16,
    parameter int BINS   = 64,
    parameter int CNT_W  = 8,
    parameter int BIN_W  = $clog2(BINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     in_valid,
    input  logic [BIN_W-1:0]         in_bin,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic [BIN_W-1:0]         out_bin,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q,
    output logic                     out_first,
    output logic [CNT_W-1:0]         sat_count
);

    import ccl_pkg::*;

    localparam int LANES = 2;

    typedef struct packed {
        logic                     valid;
        logic [BIN_W-1:0]         bin;
        logic signed [DATA_W-1:0] di;
        logic signed [DATA_W-1:0] dq;
        logic                     first;
        logic                     armed;
    } ccl_state_t;

    ccl_state_t st_d;
    ccl_state_t st_q;
    ccl_mode_e  mode;

    logic signed [DATA_W-1:0] prev_i;
    logic signed [DATA_W-1:0] prev_q;
    logic signed [DATA_W-1:0] lane_cur  [LANES];
    logic signed [DATA_W-1:0] lane_prev [LANES];
    logic signed [DATA_W-1:0] lane_diff [LANES];
    logic [LANES-1:0]         lane_clip;
    logic                     clip_evt;

    ccl_history_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (BINS),
        .ADDR_W (BIN_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_addr (in_bin),
        .wr_i    (in_i),
        .wr_q    (in_q),
        .rd_addr (in_bin),
        .rd_i    (prev_i),
        .rd_q    (prev_q)
    );

    always_comb begin
        lane_cur[0]  = in_i;
        lane_cur[1]  = in_q;
        lane_prev[0] = prev_i;
        lane_prev[1] = prev_q;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ccl_sat_lane #(
            .DATA_W (DATA_W)
        ) u_lane (
            .cur     (lane_cur[l]),
            .prev    (lane_prev[l]),
            .diff    (lane_diff[l]),
            .clipped (lane_clip[l])
        );
    end

    // Mode select: priming ends on bin 0 once the phase has taken a sample.
    always_comb begin
        if (!enable) begin
            mode = CCL_BYPASS;
        end else if (st_q.first && !(st_q.armed && in_bin == '0)) begin
            mode = CCL_PRIME;
        end else begin
            mode = CCL_CANCEL;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        clip_evt   = 1'b0;

        if (!enable) begin
            st_d.first = 1'b1;
            st_d.armed = 1'b0;
        end

        if (in_valid) begin
            st_d.bin = in_bin;
            unique case (mode)
                CCL_BYPASS: begin
                    st_d.di = in_i;
                    st_d.dq = in_q;
                end
                CCL_PRIME: begin
                    st_d.di    = '0;
                    st_d.dq    = '0;
                    st_d.armed = 1'b1;
                end
                default: begin
                    st_d.di    = lane_diff[0];
                    st_d.dq    = lane_diff[1];
                    st_d.first = 1'b0;
                    st_d.armed = 1'b0;
                    clip_evt   = |lane_clip;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    ccl_sat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (clip_evt),
        .count (sat_count)
    );

    assign out_valid = st_q.valid;
    assign out_bin   = st_q.bin;
    assign out_i     = st_q.di;
    assign out_q     = st_q.dq;
    assign out_first = st_q.first;

endmodule

// File: rtl/ccl_checker.sv
module ccl_checker #(
    parameter int DATA_W = 16,
    parameter int BIN_W  = 6,
    parameter int CNT_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     enable,
    input logic                     in_valid,
    input logic [BIN_W-1:0]         in_bin,
    input logic signed [DATA_W-1:0] in_i,
    input logic signed [DATA_W-1:0] in_q,
    input logic                     out_valid,
    input logic [BIN_W-1:0]         out_bin,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] out_q,
    input logic                     out_first,
    input logic [CNT_W-1:0]         sat_count
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_bin_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_bin == $past(in_bin));

    p_bypass_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !enable) |=> (out_i == $past(in_i) && out_q == $past(in_q)));

    p_first_while_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> out_first);

    p_prime_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enable && out_first) |=>
            (out_first || (out_valid && $past(in_bin) == '0)) &&
            (!out_first || (out_i == '0 && out_q == '0)));

    p_first_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !out_first) |=> !out_first);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sat_count == $past(sat_count) || sat_count == $past(sat_count) + ONE));

    p_count_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !enable) |=> $stable(sat_count));

endmodule

bind clutter_canceller ccl_checker #(
    .DATA_W (DATA_W),
    .BIN_W  (BIN_W),
    .CNT_W  (CNT_W)
) u_ccl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .in_valid  (in_valid),
    .in_bin    (in_bin),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_bin   (out_bin),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_first (out_first),
    .sat_count (sat_count)
);

// File: tb/sim_clutter_canceller.sv
module sim_clutter_canceller;

    localparam int PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int BINS   = 8;
    localparam int CNT_W  = 8;
    localparam int BIN_W  = $clog2(BINS);
    localparam int MAXV   = 32767;
    localparam int MINV   = -32768;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     enable = 1'b0;
    logic                     in_valid = 1'b0;
    logic [BIN_W-1:0]         in_bin = '0;
    logic signed [DATA_W-1:0] in_i = '0;
    logic signed [DATA_W-1:0] in_q = '0;
    logic                     out_valid;
    logic [BIN_W-1:0]         out_bin;
    logic signed [DATA_W-1:0] out_i;
    logic signed [DATA_W-1:0] out_q;
    logic                     out_first;
    logic [CNT_W-1:0]         sat_count;

    int checks = 0;
    int fails  = 0;

    // Reference model state, built from the requirements.
    int m_hist_i [BINS];
    int m_hist_q [BINS];
    bit m_first;
    bit m_armed;
    int m_cnt;

    always #(PERIOD/2) clk = ~clk;

    clutter_canceller #(
        .DATA_W (DATA_W),
        .BINS   (BINS),
        .CNT_W  (CNT_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .in_valid  (in_valid),
        .in_bin    (in_bin),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_bin   (out_bin),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_first (out_first),
        .sat_count (sat_count)
    );

    function automatic int clampv(int v, output bit c);
        c = 1'b0;
        if (v > MAXV) begin c = 1'b1; return MAXV; end
        if (v < MINV) begin c = 1'b1; return MINV; end
        return v;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < BINS; b++) begin
            m_hist_i[b] = 0;
            m_hist_q[b] = 0;
        end
        m_first = 1'b1;
        m_armed = 1'b0;
        m_cnt   = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        enable   = 1'b0;
        in_valid = 1'b0;
        in_bin   = '0;
        in_i     = '0;
        in_q     = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Drive one cycle at a falling edge, predict, sample at the next falling edge.
    task automatic step(input bit en, input bit vld, input int bin,
                        input int si, input int sq, input string tag);
        int ei, eq;
        bit ci, cq;
        bit ok;
        enable   = en;
        in_valid = vld;
        in_bin   = BIN_W'(bin);
        in_i     = DATA_W'(si);
        in_q     = DATA_W'(sq);
        ei = 0;
        eq = 0;
        if (!en) begin
            m_first = 1'b1;
            m_armed = 1'b0;
        end
        if (vld) begin
            if (!en) begin
                ei = si;
                eq = sq;
            end else if (m_first && !(m_armed && bin == 0)) begin
                m_armed = 1'b1;
            end else begin
                ei = clampv(si - m_hist_i[bin], ci);
                eq = clampv(sq - m_hist_q[bin], cq);
                m_first = 1'b0;
                m_armed = 1'b0;
                if ((ci || cq) && m_cnt < 255) m_cnt++;
            end
            m_hist_i[bin] = si;
            m_hist_q[bin] = sq;
        end
        @(negedge clk);
        checks++;
        ok = (out_valid == vld) && (out_first == m_first) && (int'(sat_count) == m_cnt);
        if (vld) ok = ok && (int'(out_i) == ei) && (int'(out_q) == eq) && (int'(out_bin) == bin);
        if (!ok) begin
            fails++;
            $display("FAIL %s: got v=%0d bin=%0d i=%0d q=%0d first=%0d cnt=%0d exp v=%0d bin=%0d i=%0d q=%0d first=%0d cnt=%0d",
                     tag, out_valid, out_bin, out_i, out_q, out_first, sat_count,
                     vld, bin, ei, eq, m_first, m_cnt);
        end
    endtask

    task automatic chirp(input bit en, input int base_i, input int base_q, input string tag);
        for (int b = 0; b < BINS; b++) begin
            step(en, 1'b1, b, base_i + 37 * b, base_q - 11 * b, tag);
        end
    endtask

    task automatic t_reset();
        do_reset();
        checks++;
        if (out_valid !== 1'b0 || out_first !== 1'b1 || sat_count !== '0 ||
            out_i !== '0 || out_q !== '0 || out_bin !== '0) begin
            fails++;
            $display("FAIL R8: got v=%0d first=%0d cnt=%0d i=%0d q=%0d bin=%0d exp 0 1 0 0 0 0",
                     out_valid, out_first, sat_count, out_i, out_q, out_bin);
        end
    endtask

    task automatic t_passthrough();
        do_reset();
        chirp(1'b0, 1200, -700, "R3");
        step(1'b0, 1'b0, 0, 5, 5, "R2");
        step(1'b0, 1'b1, 5, MINV, MAXV, "R3");
        step(1'b0, 1'b0, 0, 0, 0, "R2");
    endtask

    task automatic t_prime_cancel();
        do_reset();
        chirp(1'b1, 1000, 2000, "R4");
        chirp(1'b1, 1500, 1700, "R5");
        chirp(1'b1, -300, 40, "R1");
        step(1'b1, 1'b0, 3, 0, 0, "R2");
        step(1'b1, 1'b1, 3, 77, -77, "R1");
    endtask

    task automatic t_history_write();
        do_reset();
        chirp(1'b0, 9000, -9000, "R9");
        chirp(1'b1, 100, 200, "R9");
        chirp(1'b1, 400, 100, "R9");
    endtask

    task automatic t_mid_enable();
        do_reset();
        chirp(1'b1, 50, 60, "R4");
        chirp(1'b1, 70, 80, "R1");
        step(1'b0, 1'b1, 0, 3, 3, "R4");
        for (int b = 3; b < BINS; b++) step(1'b1, 1'b1, b, 10 * b, -b, "R5");
        chirp(1'b1, 500, 600, "R5");
    endtask

    task automatic t_clamp();
        do_reset();
        chirp(1'b1, 0, 0, "R4");
        step(1'b1, 1'b1, 0, MAXV, 0, "R6");
        step(1'b1, 1'b1, 1, MINV, MINV, "R6");
        step(1'b1, 1'b1, 2, 0, MAXV, "R6");
        for (int b = 3; b < BINS; b++) step(1'b1, 1'b1, b, 5, 5, "R1");
        step(1'b1, 1'b1, 0, MINV, 0, "R6");
        step(1'b1, 1'b1, 1, MAXV, MAXV, "R7");
        step(1'b1, 1'b1, 2, 0, MINV, "R6");
        step(1'b0, 1'b1, 0, MAXV, MINV, "R7");
    endtask

    task automatic t_count_sat();
        do_reset();
        chirp(1'b1, 0, 0, "R4");
        for (int c = 0; c < 36; c++) begin
            for (int b = 0; b < BINS; b++) begin
                if (c % 2 == 0) step(1'b1, 1'b1, b, MAXV, MAXV, "R7");
                else            step(1'b1, 1'b1, b, MINV, MINV, "R7");
            end
        end
        checks++;
        if (int'(sat_count) != 255) begin
            fails++;
            $display("FAIL R7: got cnt=%0d exp 255", sat_count);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_passthrough();
        t_prime_cancel();
        t_history_write();
        t_mid_enable();
        t_clamp();
        t_count_sat();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule